// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block is the host-facing register file of a single ATA device. The host reaches eight byte-wide registers through a 3-bit offset. Offset 0 is a 16-bit data port. Offset 1 holds the feature byte. Offsets 2 to 5 hold the sector count and the three LBA bytes. Offset 6 is the device/head byte. Offset 7 reads as status and takes a command opcode when written. The block keeps the busy, ready, data-request and error flags. It drives an interrupt request line, and a status read withdraws that request.

Two commands run to completion inside the block. IDENTIFY hands out a 256-word record, one word per data-port read. The words come from an external word source that the block indexes. FLUSH CACHE keeps the device busy until an external completion strobe arrives. Read DMA, write DMA and packet commands are passed on to the neighbouring blocks as a one-cycle start pulse with a direction flag. The same completion strobe then finishes them.

Top module: `ata_tf_ctrl`

## Requirements
- R1: After reset, status reads 0x40 (bit 6 ready set, all else clear), the interrupt is low, the word index is 0 and every task-file byte is 0.
- R2: Bytes written to offsets 2–6 read back unchanged in the low byte with the high byte zero. Writing 0x40 to offset 6 reads back with bit 4 (0x10, device 1 select) clear, and writing 0x50 reads back with it set. A write to offset 1 appears on `feature_o`. A read of offset 1 returns the error byte, which is 0x04 when the error flag is set and 0x00 otherwise.
- R3: While busy (status bit 7) is set, writes to offsets 1–7 change nothing. While data request (status bit 3) is set, a command write changes nothing.
- R4: Writing 0xEC sets data request and raises the interrupt. Status is 0x48 before each of the 256 data reads, and each read returns `id_word` for the current `id_index`, which starts at 0 and steps by one per read. After the 256th read, status is 0x40 and the index is 0.
- R5: A data-port read while data request is clear returns 0 and leaves `id_index` unchanged.
- R6: Writing 0xE7 makes status 0xC0 (busy plus ready) until `cmd_done` is sampled high. On the following cycle status is 0x40 and the interrupt is raised.
- R7: A host read of offset 7 drops the interrupt on the next cycle, unless a raising event occurs in the same cycle. A raising event takes priority over the clear.
- R8: Writing 0xC8 or 0xCA gives a one-cycle `dma_go` on the cycle after the write. Writing 0xA0 gives a one-cycle `pkt_go`. `xfer_to_host` is 1 for 0xC8 and 0xA0 and 0 for 0xCA. Status is 0xC0 until `cmd_done`, which then raises the interrupt.
- R9: Any other opcode gives status 0x41 (error, bit 0), error byte 0x04 and an interrupt. The next accepted command clears the error flag.
- R10: When `irq_disable` is high in the cycle of a raising event, the interrupt is not raised.
- R11: `cmd_done` while not busy has no effect on status or the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 16 | Read data for the current offset |
| irq_disable | input | 1 | Suppresses interrupt raising |
| irq | output | 1 | Interrupt request |
| id_index | output | 8 | Index of the next identify word |
| id_word | input | 16 | Identify word at `id_index` |
| cmd_done | input | 1 | Completion strobe for flush and handed-off commands |
| dma_go | output | 1 | One-cycle DMA command start |
| pkt_go | output | 1 | One-cycle packet command start |
| xfer_to_host | output | 1 | Direction of the handed-off transfer, 1 = device to host |
| feature_o | output | 8 | Current feature byte |

## Verification
The hardest state to reach is the middle of an identify transfer with the data request set: a second command is written there and must be ignored, and the word counter must wrap back exactly at the last word. The stimulus walks all 256 words. It alternates a status read and a data read so that the status value is seen before every word. At word 100 it inserts a flush opcode. A reference model in the bench runs beside the design and compares read data, the interrupt, the start pulses and the word index on every clock. Interrupt masking and stray completion strobes are exercised with the model tracking the interrupt state.

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl #(
  parameter int WORDS = 256,
  parameter int DW    = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [7:0]       host_wdata,
  output logic [DW-1:0]    host_rdata,
  input  logic             irq_disable,
  output logic             irq,
  output logic [IDX_W-1:0] id_index,
  input  logic [DW-1:0]    id_word,
  input  logic             cmd_done,
  output logic             dma_go,
  output logic             pkt_go,
  output logic             xfer_to_host,
  output logic [7:0]       feature_o
);
  localparam logic [2:0] A_DATA = 3'd0, A_FEAT = 3'd1, A_CNT = 3'd2, A_LO = 3'd3,
                         A_MID = 3'd4, A_HI = 3'd5, A_DEV = 3'd6, A_CMD = 3'd7;
  localparam logic [7:0] OP_IDENT = 8'hEC, OP_FLUSH = 8'hE7, OP_RDMA = 8'hC8,
                         OP_WDMA = 8'hCA, OP_PKT = 8'hA0;

  logic bsy, drq, err;
  logic [7:0] feat, cnt, lo, mid, hi, dev;
  logic [IDX_W-1:0] idx;

  wire known   = (host_wdata == OP_IDENT) || (host_wdata == OP_FLUSH) ||
                 (host_wdata == OP_RDMA)  || (host_wdata == OP_WDMA)  ||
                 (host_wdata == OP_PKT);
  wire cmd_wr  = host_wr && (host_addr == A_CMD) && !bsy && !drq;
  wire data_rd = host_rd && (host_addr == A_DATA) && drq;
  wire last    = (idx == IDX_W'(WORDS - 1));
  wire stat_rd = host_rd && (host_addr == A_CMD);
  wire raise   = (cmd_wr && (host_wdata == OP_IDENT || !known)) || (cmd_done && bsy);
  wire [7:0] status = {bsy, 1'b1, 2'b00, drq, 2'b00, err};

  assign id_index  = idx;
  assign feature_o = feat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      feat <= '0; cnt <= '0; lo <= '0; mid <= '0; hi <= '0; dev <= '0;
    end else if (host_wr && !bsy) begin
      case (host_addr)
        A_FEAT:  feat <= host_wdata;
        A_CNT:   cnt  <= host_wdata;
        A_LO:    lo   <= host_wdata;
        A_MID:   mid  <= host_wdata;
        A_HI:    hi   <= host_wdata;
        A_DEV:   dev  <= host_wdata;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bsy <= 1'b0; drq <= 1'b0; err <= 1'b0; idx <= '0;
      dma_go <= 1'b0; pkt_go <= 1'b0; xfer_to_host <= 1'b0; irq <= 1'b0;
    end else begin
      dma_go <= 1'b0;
      pkt_go <= 1'b0;
      if (cmd_wr) begin
        err <= !known;
        case (host_wdata)
          OP_IDENT: begin drq <= 1'b1; idx <= '0; end
          OP_FLUSH: bsy <= 1'b1;
          OP_RDMA:  begin bsy <= 1'b1; dma_go <= 1'b1; xfer_to_host <= 1'b1; end
          OP_WDMA:  begin bsy <= 1'b1; dma_go <= 1'b1; xfer_to_host <= 1'b0; end
          OP_PKT:   begin bsy <= 1'b1; pkt_go <= 1'b1; xfer_to_host <= 1'b1; end
          default:  ;
        endcase
      end
      if (data_rd) begin
        if (last) begin drq <= 1'b0; idx <= '0; end
        else idx <= idx + IDX_W'(1);
      end
      if (cmd_done && bsy) bsy <= 1'b0;
      if (raise && !irq_disable) irq <= 1'b1;
      else if (stat_rd) irq <= 1'b0;
    end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_DATA: if (drq) host_rdata = id_word;
      A_FEAT: host_rdata[7:0] = {5'b00000, err, 2'b00};
      A_CNT:  host_rdata[7:0] = cnt;
      A_LO:   host_rdata[7:0] = lo;
      A_MID:  host_rdata[7:0] = mid;
      A_HI:   host_rdata[7:0] = hi;
      A_DEV:  host_rdata[7:0] = dev;
      A_CMD:  host_rdata[7:0] = status;
    endcase
  end

  AST_BSY_DRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(bsy && drq)); // R4
  AST_LAST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && last) |=> (!drq && idx == '0)); // R4
  AST_IDLE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == A_DATA && !drq) |=> $stable(idx)); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && !cmd_done) |=> bsy); // R6
  AST_DONE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && cmd_done) |=> !bsy); // R6
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == A_CMD && !host_wr && !cmd_done) |=> !irq); // R7
  AST_GO_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({dma_go, pkt_go})); // R8
  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n) dma_go |=> !dma_go); // R8
  AST_BUSY_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && host_wr && host_addr == A_CNT) |=> $stable(cnt)); // R3
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_disable && !irq) |=> !irq); // R10
  AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bsy && cmd_done && !host_wr && !irq) |=> !irq); // R11
endmodule

// File: tb/ata_tf_ctrl_tb_top.sv
module ata_tf_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic host_wr = 1'b0, host_rd = 1'b0, irq_disable = 1'b0, cmd_done = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [15:0] host_rdata, id_word;
  logic irq, dma_go, pkt_go, xfer_to_host;
  logic [7:0] id_index, feature_o;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign id_word = {~id_index, id_index};

  ata_tf_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_disable(irq_disable), .irq(irq),
    .id_index(id_index), .id_word(id_word), .cmd_done(cmd_done), .dma_go(dma_go),
    .pkt_go(pkt_go), .xfer_to_host(xfer_to_host), .feature_o(feature_o));

  int checks = 0, errors = 0;
  bit finished = 0;

  bit m_bsy = 0, m_drq = 0, m_err = 0, m_irq = 0, m_dgo = 0, m_pgo = 0, m_dir = 0;
  int m_idx = 0;
  logic [7:0] m_tf [0:7];
  bit r_ev, b0, d0;

  initial for (int k = 0; k < 8; k++) m_tf[k] = 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bsy = 0; m_drq = 0; m_err = 0; m_irq = 0; m_dgo = 0; m_pgo = 0; m_dir = 0; m_idx = 0;
      for (int k = 0; k < 8; k++) m_tf[k] = 8'h00;
    end else begin
      r_ev = 0; b0 = m_bsy; d0 = m_drq; m_dgo = 0; m_pgo = 0;
      if (host_wr && host_addr >= 1 && host_addr <= 6 && !b0) m_tf[host_addr] = host_wdata;
      if (host_wr && host_addr == 7 && !b0 && !d0) begin
        m_err = 0;
        case (host_wdata)
          8'hEC: begin m_drq = 1; m_idx = 0; r_ev = 1; end
          8'hE7: m_bsy = 1;
          8'hC8: begin m_bsy = 1; m_dgo = 1; m_dir = 1; end
          8'hCA: begin m_bsy = 1; m_dgo = 1; m_dir = 0; end
          8'hA0: begin m_bsy = 1; m_pgo = 1; m_dir = 1; end
          default: begin m_err = 1; r_ev = 1; end
        endcase
      end
      if (host_rd && host_addr == 7) m_irq = 0;
      if (host_rd && host_addr == 0 && d0) begin
        if (m_idx == 255) begin m_drq = 0; m_idx = 0; end
        else m_idx++;
      end
      if (cmd_done && b0) begin m_bsy = 0; r_ev = 1; end
      if (r_ev && !irq_disable) m_irq = 1;
    end
  end

  function automatic logic [15:0] exp_rdata(input logic [2:0] a);
    logic [7:0] ix;
    ix = m_idx[7:0];
    case (a)
      3'd0: return m_drq ? {~ix, ix} : 16'h0000;
      3'd1: return {13'h0000, m_err, 2'b00};
      3'd7: return {8'h00, m_bsy, 1'b1, 2'b00, m_drq, 2'b00, m_err};
      default: return {8'h00, m_tf[a]};
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [63:0] a, e;
    a = {host_rdata, irq, dma_go, pkt_go, xfer_to_host, id_index, feature_o};
    e = {exp_rdata(host_addr), m_irq, m_dgo, m_pgo, m_dir, m_idx[7:0], m_tf[1]};
    chk(a === e, {tag, " model"}, a, e);
  endtask

  task automatic cyc(input logic [2:0] a, input bit w, input bit r, input logic [7:0] d,
                     input bit dn, input string tag);
    @(negedge clk);
    host_addr = a; host_wr = w; host_rd = r; host_wdata = d; cmd_done = dn;
    #1;
    compare_all(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    cyc(a, 1, 0, d, 0, tag);
  endtask
  task automatic rd(input logic [2:0] a, input string tag);
    cyc(a, 0, 1, 8'h00, 0, tag);
  endtask
  task automatic idle(input string tag);
    cyc(3'd0, 0, 0, 8'h00, 0, tag);
  endtask
  task automatic done(input string tag);
    cyc(3'd0, 0, 0, 8'h00, 1, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd7, "R1");
    chk(host_rdata == 16'h0040, "R1 status", host_rdata, 16'h0040);
    chk(irq == 1'b0 && id_index == 8'h00, "R1 irq/index", {irq, id_index}, 9'h000);

    wr(3'd2, 8'h11, "R2"); wr(3'd3, 8'h22, "R2"); wr(3'd4, 8'h33, "R2");
    wr(3'd5, 8'h44, "R2"); wr(3'd6, 8'h40, "R2"); wr(3'd1, 8'h01, "R2");
    rd(3'd2, "R2"); chk(host_rdata == 16'h0011, "R2 count", host_rdata, 16'h0011);
    chk(feature_o == 8'h01, "R2 feature", feature_o, 8'h01);
    rd(3'd5, "R2"); chk(host_rdata == 16'h0044, "R2 lba high", host_rdata, 16'h0044);
    rd(3'd6, "R2"); chk(host_rdata == 16'h0040, "R2 device bit4 clear", host_rdata, 16'h0040);
    wr(3'd6, 8'h50, "R2");
    rd(3'd6, "R2"); chk(host_rdata == 16'h0050, "R2 device bit4 set", host_rdata, 16'h0050);
    wr(3'd6, 8'h40, "R2");
    rd(3'd1, "R2"); chk(host_rdata == 16'h0000, "R2 error byte", host_rdata, 16'h0000);

    rd(3'd0, "R5"); chk(host_rdata == 16'h0000, "R5 idle data", host_rdata, 16'h0000);
    idle("R5"); chk(id_index == 8'h00, "R5 index", id_index, 8'h00);

    wr(3'd7, 8'hEC, "R4");
    idle("R4"); chk(irq == 1'b1, "R4 irq", irq, 1'b1);
    for (int i = 0; i < 256; i++) begin
      rd(3'd7, "R4");
      chk(host_rdata == 16'h0048, "R4 status per word", host_rdata, 16'h0048);
      rd(3'd0, "R4");
      chk(host_rdata == {~i[7:0], i[7:0]}, "R4 word", host_rdata, {~i[7:0], i[7:0]});
      if (i == 100) begin
        wr(3'd7, 8'hE7, "R3");
        rd(3'd7, "R3");
        chk(host_rdata == 16'h0048, "R3 command during transfer", host_rdata, 16'h0048);
      end
    end
    rd(3'd7, "R4"); chk(host_rdata == 16'h0040, "R4 final status", host_rdata, 16'h0040);
    chk(irq == 1'b0 && id_index == 8'h00, "R4 final irq/index", {irq, id_index}, 9'h000);

    wr(3'd7, 8'hE7, "R6");
    repeat (3) idle("R6");
    rd(3'd7, "R6"); chk(host_rdata == 16'h00C0, "R6 in flight", host_rdata, 16'h00C0);
    wr(3'd2, 8'h99, "R3");
    wr(3'd7, 8'h55, "R3");
    done("R6");
    idle("R6"); chk(irq == 1'b1, "R6 irq", irq, 1'b1);
    rd(3'd7, "R6"); chk(host_rdata == 16'h0040, "R6 complete", host_rdata, 16'h0040);
    rd(3'd2, "R3"); chk(host_rdata == 16'h0011, "R3 busy write ignored", host_rdata, 16'h0011);
    chk(irq == 1'b0, "R7 cleared by status read", irq, 1'b0);

    wr(3'd7, 8'hC8, "R8");
    idle("R8"); chk(dma_go && xfer_to_host && !pkt_go, "R8 read dma go", {dma_go, xfer_to_host, pkt_go}, 3'b110);
    idle("R8"); chk(dma_go == 1'b0, "R8 pulse width", dma_go, 1'b0);
    done("R8"); idle("R8");
    chk(irq == 1'b1, "R8 completion irq", irq, 1'b1);
    rd(3'd7, "R7");
    wr(3'd7, 8'hCA, "R8");
    idle("R8"); chk(dma_go && !xfer_to_host, "R8 write dma go", {dma_go, xfer_to_host}, 2'b10);
    done("R8"); rd(3'd7, "R7");
    wr(3'd7, 8'hA0, "R8");
    idle("R8"); chk(pkt_go && !dma_go && xfer_to_host, "R8 packet go", {pkt_go, dma_go, xfer_to_host}, 3'b101);
    rd(3'd7, "R8"); chk(host_rdata == 16'h00C0, "R8 busy", host_rdata, 16'h00C0);
    done("R8"); idle("R8"); rd(3'd7, "R8");
    chk(host_rdata == 16'h0040, "R8 done status", host_rdata, 16'h0040);

    idle("R11"); done("R11"); idle("R11");
    chk(irq == 1'b0, "R11 stray done irq", irq, 1'b0);
    rd(3'd7, "R11"); chk(host_rdata == 16'h0040, "R11 stray done status", host_rdata, 16'h0040);

    wr(3'd7, 8'h55, "R9");
    idle("R9"); chk(irq == 1'b1, "R9 irq", irq, 1'b1);
    rd(3'd7, "R9"); chk(host_rdata == 16'h0041, "R9 status", host_rdata, 16'h0041);
    rd(3'd1, "R9"); chk(host_rdata == 16'h0004, "R9 error byte", host_rdata, 16'h0004);
    wr(3'd7, 8'hE7, "R9");
    rd(3'd7, "R9"); chk(host_rdata == 16'h00C0, "R9 error cleared", host_rdata, 16'h00C0);
    done("R9"); idle("R9");

    irq_disable = 1'b1;
    rd(3'd7, "R10");
    wr(3'd7, 8'hE7, "R10"); done("R10"); idle("R10");
    chk(irq == 1'b0, "R10 masked completion", irq, 1'b0);
    wr(3'd7, 8'h33, "R10"); idle("R10");
    chk(irq == 1'b0, "R10 masked error", irq, 1'b0);
    rd(3'd7, "R10"); chk(host_rdata == 16'h0041, "R10 status", host_rdata, 16'h0041);
    irq_disable = 1'b0;
    idle("R10");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule